// File: doc/BRIEF.md
# Multi-Mode Hierarchical Page Walker

This block turns a 32-bit linear address into a physical address. It walks page tables held in memory, one read per level. A requester presents the linear address together with a root pointer and two mode bits. The first mode bit, `req_ext`, selects 64-bit entries with a four-entry top table and 36-bit physical addresses. The second, `req_big`, allows large pages to end the walk at the directory. The walker reads through a valid/ready memory port that keeps at most one read in flight. It ends each walk with a one-cycle `done` pulse. On that pulse it reports either a physical address or a fault, raised when a fetched entry is not marked present.

With `req_ext` clear, every entry is 32 bits. The walk uses a 10-bit directory index, then either a 10-bit table index with a 4 KB offset, or a 22-bit offset into a 4 MB page. With `req_ext` set, every entry is 64 bits. The top 2 address bits pick one of four pointer entries, and each lower level takes a 9-bit index. The walk ends in either a 4 KB page or a 2 MB page. The requester keeps the root and mode bits stable during a walk. The walker also captures them when it accepts the request.

Top module: `xlate_walker`

## Requirements
- R1: With req_ext=0 and a 4 KB leaf, two reads are made. The first is at {root[31:12], lin[31:22], 00}. The second is at {dir[31:12], lin[21:12], 00}. The result is {tbl[31:12], lin[11:0]}.
- R2: With req_ext=0, req_big=1 and directory bit 7 set, exactly one read is made. The result is {dir[31:22], lin[21:0]}.
- R3: With req_big=1 and directory bit 7 clear, the walk goes on to the page table as in R1 (or R4).
- R4: With req_ext=1 and a 4 KB leaf, three reads are made. The reads are at {root[31:5], lin[31:30], 000}, then {ptr[35:12], lin[29:21], 000}, then {dir[35:12], lin[20:12], 000}. The result is {tbl[35:12], lin[11:0]}.
- R5: With req_ext=1, req_big=1 and directory bit 7 set, two reads are made. The result is {dir[35:21], lin[20:0]}.
- R6: Bit 0 of every entry is the present flag. If any fetched entry has bit 0 clear, the walk ends on that read: `done` pulses with `fault`=1, `phys` is 0 and no further read is issued.
- R7: With req_big=0, directory bit 7 has no effect and the walk always reaches the page table.
- R8: At most one read is in flight. The first read is issued only after a request is accepted, and a pending read holds its address stable until `mem_req_ready`.
- R9: `req_ready` is high only while idle. A request raised during a walk does not change the walk's reads or result. `done` is high for exactly one cycle per walk.
- R10: After reset, `req_ready`=1 and `done`, `fault` and `mem_req_valid` are 0.
- R11: With req_ext=0, bits 63:32 of the read data have no effect on addresses or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle and accepting |
| req_lin | input | 32 | Linear address |
| req_root | input | 32 | Root pointer for the top table |
| req_ext | input | 1 | 64-bit entry / 36-bit address mode |
| req_big | input | 1 | Large-page enable |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended on a non-present entry |
| phys | output | 36 | Translated physical address |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 36 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data (low half only in 32-bit mode) |

## Verification
Two things can land in the same clock edge: a new request arriving while the walker is busy, and a read response being consumed. The bench raises `req_valid` with an unrelated address in exactly the cycle it returns the first read's data. It then checks that every later read address, the read count and the final result still match the original request. Random ready stalls and response latencies move the response edge against the request, so the two also meet at varied points of the walk.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int LIN_W     = 32;
  localparam int PA_W      = 36;
  localparam int ENT_W     = 64;
  localparam int ROOT_HI_W = LIN_W - 5;
  localparam int PRES_BIT  = 0;
  localparam int BIG_BIT   = 7;

  typedef enum logic [1:0] {LV_PTR = 2'd0, LV_DIR = 2'd1, LV_TBL = 2'd2} lvl_e;

  // Byte address of the entry read at level lv.
  function automatic logic [PA_W-1:0] walk_addr(lvl_e lv, logic ext,
      logic [ROOT_HI_W-1:0] root_hi, logic [LIN_W-1:0] lin, logic [ENT_W-1:0] ent);
    case (lv)
      LV_PTR:  return {4'b0, root_hi, lin[31:30], 3'b000};
      LV_DIR:  return ext ? {ent[35:12], lin[29:21], 3'b000}
                          : {4'b0, root_hi[26:7], lin[31:22], 2'b00};
      default: return ext ? {ent[35:12], lin[20:12], 3'b000}
                          : {4'b0, ent[31:12], lin[21:12], 2'b00};
    endcase
  endfunction

  // Final physical address when entry ent ends the walk at level lv.
  function automatic logic [PA_W-1:0] leaf_addr(lvl_e lv, logic ext,
      logic [LIN_W-1:0] lin, logic [ENT_W-1:0] ent);
    if (lv == LV_DIR)
      return ext ? {ent[35:21], lin[20:0]} : {4'b0, ent[31:22], lin[21:0]};
    return ext ? {ent[35:12], lin[11:0]} : {4'b0, ent[31:12], lin[11:0]};
  endfunction

  function automatic logic is_leaf(lvl_e lv, logic big, logic [ENT_W-1:0] ent);
    return (lv == LV_TBL) || (lv == LV_DIR && big && ent[BIG_BIT]);
  endfunction

  function automatic lvl_e next_lvl(lvl_e lv);
    return (lv == LV_PTR) ? LV_DIR : LV_TBL;
  endfunction
endpackage

// File: rtl/xw_addr_gen.sv
module xw_addr_gen
  import xw_pkg::*;
(
  input  lvl_e                 lvl,
  input  logic                 ext,
  input  logic [ROOT_HI_W-1:0] root_hi,
  input  logic [LIN_W-1:0]     lin,
  input  logic [ENT_W-1:0]     prev_ent,
  output logic [PA_W-1:0]      addr
);
  assign addr = walk_addr(lvl, ext, root_hi, lin, prev_ent);
endmodule

// File: rtl/xw_entry_dec.sv
module xw_entry_dec
  import xw_pkg::*;
(
  input  lvl_e              lvl,
  input  logic              ext,
  input  logic              big,
  input  logic [LIN_W-1:0]  lin,
  input  logic [ENT_W-1:0]  raw,
  output logic [ENT_W-1:0]  ent,
  output logic              present,
  output logic              leaf,
  output logic [PA_W-1:0]   pa
);
  localparam int HALF = ENT_W / 2;

  // 32-bit entry modes see only the low half of the read data.
  assign ent     = ext ? raw : {{HALF{1'b0}}, raw[HALF-1:0]};
  assign present = ent[PRES_BIT];
  assign leaf    = is_leaf(lvl, big, ent);
  assign pa      = leaf_addr(lvl, ext, lin, ent);
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
  import xw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LIN_W-1:0] req_lin,
  input  logic [LIN_W-1:0] req_root,
  input  logic             req_ext,
  input  logic             req_big,
  output logic             done,
  output logic             fault,
  output logic [PA_W-1:0]  phys,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [ENT_W-1:0] mem_rsp_data
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_e;

  st_e                  st;
  lvl_e                 lvl_q;
  logic [LIN_W-1:0]     lin_q;
  logic [ROOT_HI_W-1:0] root_q;
  logic                 ext_q, big_q;
  logic [ENT_W-1:0]     ent_q;

  // Named events for the checker.
  logic accept, issue_fire, rsp_take;
  logic [ENT_W-1:0] dec_ent;
  logic dec_present, dec_leaf;
  logic [PA_W-1:0] dec_pa;

  assign req_ready     = (st == S_IDLE);
  assign accept        = req_valid && req_ready;
  assign mem_req_valid = (st == S_REQ);
  assign issue_fire    = mem_req_valid && mem_req_ready;
  assign rsp_take      = (st == S_WAIT) && mem_rsp_valid;

  xw_addr_gen u_addr (
    .lvl(lvl_q), .ext(ext_q), .root_hi(root_q), .lin(lin_q),
    .prev_ent(ent_q), .addr(mem_req_addr)
  );

  xw_entry_dec u_dec (
    .lvl(lvl_q), .ext(ext_q), .big(big_q), .lin(lin_q), .raw(mem_rsp_data),
    .ent(dec_ent), .present(dec_present), .leaf(dec_leaf), .pa(dec_pa)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      lvl_q  <= LV_DIR;
      lin_q  <= '0;
      root_q <= '0;
      ext_q  <= 1'b0;
      big_q  <= 1'b0;
      ent_q  <= '0;
      done   <= 1'b0;
      fault  <= 1'b0;
      phys   <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          lin_q  <= req_lin;
          root_q <= req_root[LIN_W-1:5];
          ext_q  <= req_ext;
          big_q  <= req_big;
          lvl_q  <= req_ext ? LV_PTR : LV_DIR;
          fault  <= 1'b0;
          phys   <= '0;
          st     <= S_REQ;
        end
        S_REQ: if (issue_fire) st <= S_WAIT;
        S_WAIT: if (rsp_take) begin
          ent_q <= dec_ent;
          if (!dec_present) begin
            fault <= 1'b1;
            done  <= 1'b1;
            st    <= S_IDLE;
          end else if (dec_leaf) begin
            phys <= dec_pa;
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            lvl_q <= next_lvl(lvl_q);
            st    <= S_REQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xlate_walker_chk.sv
module xlate_walker_chk
  import xw_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            accept,
  input logic            issue_fire,
  input logic            req_ready,
  input logic            done,
  input logic            fault,
  input logic [PA_W-1:0] phys,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            walk_ext,
  input logic            walk_big
);
  logic [2:0] rd_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rd_cnt <= '0;
    else if (accept)     rd_cnt <= '0;
    else if (issue_fire) rd_cnt <= rd_cnt + 3'd1;
  end

  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid);                                    // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                  // R9
  AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> phys == '0);                                            // R6
  AST_READS_SMALL32: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault && !walk_ext && !walk_big |-> rd_cnt == 3'd2);     // R1
  AST_READS_SMALL64: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault && walk_ext && !walk_big |-> rd_cnt == 3'd3);      // R4
  AST_READS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt <= 3'd3);                                                  // R4
endmodule

bind xlate_walker xlate_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .issue_fire(issue_fire),
  .req_ready(req_ready), .done(done), .fault(fault), .phys(phys),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .walk_ext(ext_q), .walk_big(big_q)
);

// File: tb/xlate_walker_tb.sv
`timescale 1ns/1ps
module xlate_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_lin = '0, req_root = '0;
  logic        req_ext = 1'b0, req_big = 1'b0;
  logic        done, fault;
  logic [35:0] phys;
  logic        mem_req_valid, mem_req_ready = 1'b0;
  logic [35:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  xlate_walker u_dut (.*);

  logic [63:0] ent[3];
  logic [35:0] exp_a[3];
  logic [35:0] seen_a[4];
  int          exp_n;
  bit          exp_f;
  logic [35:0] exp_pa;

  task automatic check(bit ok, string rq, string what, logic [63:0] act, logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, expv);
    end
  endtask

  function automatic logic [63:0] mk_ent(bit pres, bit bigp);
    logic [63:0] e = {$urandom(), $urandom()};
    e[0] = pres;
    e[7] = bigp;
    return e;
  endfunction

  // Reference walk, built from the requirement text with plain arithmetic.
  task automatic model(input logic [31:0] lin, input logic [31:0] root, input bit x, input bit b);
    logic [63:0] e, l64, t;
    l64 = {32'h0, lin};
    exp_n = 0; exp_f = 1'b0; exp_pa = '0;
    if (x) begin
      t = (root & 32'hFFFF_FFE0) + (l64 >> 30) * 8;
      exp_a[0] = t[35:0]; exp_n = 1; e = ent[0];
      if (!e[0]) begin exp_f = 1'b1; return; end
      t = ((e >> 12) & 64'hFF_FFFF) * 4096 + ((l64 >> 21) & 511) * 8;
      exp_a[1] = t[35:0]; exp_n = 2; e = ent[1];
      if (!e[0]) begin exp_f = 1'b1; return; end
      if (b && e[7]) begin
        t = ((e >> 21) & 64'h7FFF) * 64'h20_0000 + (l64 & 64'h1F_FFFF);
        exp_pa = t[35:0]; return;
      end
      t = ((e >> 12) & 64'hFF_FFFF) * 4096 + ((l64 >> 12) & 511) * 8;
      exp_a[2] = t[35:0]; exp_n = 3; e = ent[2];
      if (!e[0]) begin exp_f = 1'b1; return; end
      t = ((e >> 12) & 64'hFF_FFFF) * 4096 + (l64 & 64'hFFF);
      exp_pa = t[35:0];
    end else begin
      t = (root & 32'hFFFF_F000) + (l64 >> 22) * 4;
      exp_a[0] = t[35:0]; exp_n = 1; e = ent[0] & 64'hFFFF_FFFF;
      if (!e[0]) begin exp_f = 1'b1; return; end
      if (b && e[7]) begin
        t = (e & 64'hFFC0_0000) + (l64 & 64'h3F_FFFF);
        exp_pa = t[35:0]; return;
      end
      t = (e & 64'hFFFF_F000) + ((l64 >> 12) & 1023) * 4;
      exp_a[1] = t[35:0]; exp_n = 2; e = ent[1] & 64'hFFFF_FFFF;
      if (!e[0]) begin exp_f = 1'b1; return; end
      t = (e & 64'hFFFF_F000) + (l64 & 64'hFFF);
      exp_pa = t[35:0];
    end
  endtask

  task automatic walk(string rq, logic [31:0] lin, logic [31:0] root, bit x, bit b, bit poke);
    int nseen = 0, lat = 0, cyc = 0;
    bit pend = 1'b0, got = 1'b0, poked = 1'b0, rfault;
    logic [35:0] rphys;
    model(lin, root, x, b);
    @(negedge clk);
    req_valid = 1'b1; req_lin = lin; req_root = root; req_ext = x; req_big = b;
    @(negedge clk);
    req_valid = 1'b0;
    while (!got && cyc < 300) begin
      if (done) begin
        got = 1'b1; rfault = fault; rphys = phys;
      end else begin
        mem_rsp_valid = 1'b0;
        req_valid     = 1'b0;
        req_lin       = lin;
        mem_req_ready = 1'b0;
        if (pend) begin
          if (lat == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = ent[nseen-1];
            pend = 1'b0;
            if (poke && !poked) begin
              // R9: new request lands on the same edge as a response.
              poked = 1'b1;
              check(req_ready == 1'b0, "R9", "ready while busy", req_ready, 0);
              req_valid = 1'b1; req_lin = ~lin;
            end
          end else lat--;
        end else if (mem_req_valid && ($urandom() % 3 != 0)) begin
          mem_req_ready = 1'b1;
          if (nseen < 4) seen_a[nseen] = mem_req_addr;
          nseen++;
          pend = 1'b1;
          lat  = $urandom() % 3;
        end
        @(negedge clk);
        cyc++;
      end
    end
    mem_rsp_valid = 1'b0; mem_req_ready = 1'b0; req_valid = 1'b0;
    check(got, rq, "walk completed", {63'b0, got}, 1);
    if (got) begin
      check(nseen == exp_n, rq, "read count", nseen, exp_n);
      for (int i = 0; i < 3; i++)
        if (i < exp_n && i < nseen)
          check(seen_a[i] == exp_a[i], rq, $sformatf("read %0d address", i), seen_a[i], exp_a[i]);
      check(rfault == exp_f, exp_f ? "R6" : rq, "fault", rfault, exp_f);
      check(rphys == exp_pa, exp_f ? "R6" : rq, "phys", rphys, exp_pa);
      @(negedge clk);
      check(done == 1'b0, "R9", "done one cycle", done, 0);
      check(mem_req_valid == 1'b0, "R8", "no read after done", mem_req_valid, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10 reset state
    check(req_ready == 1'b1, "R10", "req_ready", req_ready, 1);
    check(done == 1'b0, "R10", "done", done, 0);
    check(fault == 1'b0, "R10", "fault", fault, 0);
    check(mem_req_valid == 1'b0, "R10", "mem_req_valid", mem_req_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: 32-bit entries, small page
    ent[0] = mk_ent(1, 0); ent[1] = mk_ent(1, 0); ent[2] = mk_ent(1, 0);
    walk("R1", 32'h1234_5678, 32'h0ABC_D000, 0, 0, 0);
    // R11: upper half all ones must not leak in
    ent[0] = {32'hFFFF_FFFF, 32'h0040_0001}; ent[1] = {32'hFFFF_FFFF, 32'h0080_0081};
    walk("R11", 32'hFFFF_FFFF, 32'h0000_1000, 0, 0, 0);
    check(exp_pa[35:32] == 4'h0, "R11", "model top bits", exp_pa[35:32], 0);
    // R2: large 4 MB page
    ent[0] = mk_ent(1, 1);
    walk("R2", 32'hC03F_FFFF, 32'h7777_7000, 0, 1, 0);
    // R3: big enabled, bit 7 clear
    ent[0] = mk_ent(1, 0); ent[1] = mk_ent(1, 1);
    walk("R3", 32'h8765_4321, 32'h1111_1000, 0, 1, 0);
    // R7: big disabled, bit 7 set in directory
    ent[0] = mk_ent(1, 1); ent[1] = mk_ent(1, 1);
    walk("R7", 32'h0040_1FFF, 32'h2222_2000, 0, 0, 0);
    ent[0] = mk_ent(1, 0); ent[1] = mk_ent(1, 1); ent[2] = mk_ent(1, 0);
    walk("R7", 32'hFFE0_0000, 32'h3333_33E0, 1, 0, 0);
    // R4: 64-bit entries, small page
    ent[0] = mk_ent(1, 0); ent[1] = mk_ent(1, 0); ent[2] = mk_ent(1, 1);
    walk("R4", 32'hDEAD_BEEF, 32'hFFFF_FFE0, 1, 0, 0);
    // R5: 2 MB page
    ent[0] = mk_ent(1, 1); ent[1] = mk_ent(1, 1);
    walk("R5", 32'h7FFF_FFFF, 32'h0000_0020, 1, 1, 0);
    // R6: non-present at each level
    ent[0] = mk_ent(0, 0); walk("R6", 32'h1000_0000, 32'h4000_0000, 0, 0, 0);
    ent[0] = mk_ent(1, 0); ent[1] = mk_ent(0, 0); walk("R6", 32'h2000_0000, 32'h4000_0000, 0, 0, 0);
    ent[0] = mk_ent(1, 0); ent[1] = mk_ent(1, 0); ent[2] = mk_ent(0, 0);
    walk("R6", 32'h3000_0000, 32'h4000_0000, 1, 1, 0);
    // R9: request during walk, coinciding with a response
    ent[0] = mk_ent(1, 0); ent[1] = mk_ent(1, 0); ent[2] = mk_ent(1, 0);
    walk("R9", 32'h5A5A_5A5A, 32'h6000_0000, 1, 0, 1);
    walk("R9", 32'hA5A5_A5A5, 32'h6000_0000, 0, 1, 1);

    // Random walks across all four modes
    for (int k = 0; k < 300; k++) begin
      bit x = $urandom() % 2, b = $urandom() % 2;
      string rq;
      for (int i = 0; i < 3; i++) ent[i] = mk_ent(($urandom() % 10) != 0, $urandom() % 2);
      rq = x ? (b && ent[1][7] ? "R5" : "R4") : (b && ent[0][7] ? "R2" : "R1");
      walk(rq, $urandom(), $urandom(), x, b, ($urandom() % 4) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule